// File: doc/BRIEF.md
# Selectable Matched Filter Chain

This block filters a stream of complex baseband samples for symbol detection. Four filter paths are available. The first passes samples straight through. The second is a fixed 15-tap root raised cosine FIR for shaped pulses. The third is an integrate-and-dump decimator for square pulses. The fourth puts the decimator ahead of the FIR, which gives square-pulse data better rejection of the neighbouring channel. In every mode the output is meant to arrive at two samples per symbol. In bypass and FIR-only modes the caller must therefore supply two samples per symbol. In the decimating modes the caller can supply up to 32 samples per symbol and programs the dump ratio to match.

A small controller has two states, FLUSH and RUN. Reset enters FLUSH. FLUSH always moves to RUN after exactly one cycle. RUN stays in RUN while the mode input equals the registered mode. RUN moves to FLUSH in the cycle the mode input differs from the registered mode. The change cycle and the FLUSH cycle both clear every delay line, accumulator and the window counter, and samples presented in those two cycles are dropped. The caller can also restart the integration window through a strobe. This lets the window boundary follow an external symbol boundary.

Top module: `mfc_chain`

## Requirements
- R1: Mode code 2'b00 is bypass. Each accepted sample appears unchanged on both lanes. out_valid is high in the second cycle after the clock edge that accepted it, so the latency is 2 cycles in every mode.
- R2: Mode code 2'b01 is FIR only. It produces one output per accepted input: y = sat((sum over k of c[k]*x[n-k] + 128) >>> 8). The taps are c[0..14] = -3, 8, 12, -15, -37, 21, 166, 255, 166, 21, -37, -15, 12, 8, -3, with history taken as zero after a clear.
- R3: Mode code 2'b10 is integrate-and-dump. The decimator sums R consecutive accepted samples and emits one output per R samples. The output equals sat(sum >>> floor(log2 R)), using arithmetic shift (floor), and the sum then restarts from zero.
- R4: A dump ratio of 0 acts as 1. A ratio above 16 acts as 16.
- R5: Mode code 2'b11 cascades the two filters. The decimator output, as defined in R3, is the input of the FIR, as defined in R2.
- R6: Every filtered result saturates to the signed 12-bit range [-2048, 2047].
- R7: A window-restart strobe discards the partial sum and count. A sample accepted in the same cycle becomes the first sample of the new window.
- R8: A mode change drops the samples presented in the change cycle and in the following cycle. It also clears the FIR history and the decimator state. out_valid stays low for the two cycles after any clear.
- R9: After reset out_valid is low and the registered mode is bypass.
- R10: FLUSH lasts exactly one cycle. A sample presented in the third cycle after a mode change is accepted.
- R11: The I and Q lanes are processed identically and independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Filter path select (see R1, R2, R3, R5) |
| dump_ratio | input | 5 | Samples per dump, 1 to 16 |
| sym_clr | input | 1 | Restart the integration window |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Signed in-phase input |
| in_q | input | 12 | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Signed in-phase output |
| out_q | output | 12 | Signed quadrature output |

## Verification
Two events can land in the same cycle: a window restart and the sample that would otherwise finish a dump. The bench provokes this by raising the restart strobe together with a valid sample part-way through a ratio-4 window. It judges the result by requiring exactly one dump whose value covers only the restart sample and the three samples after it. A mode change can also coincide with a valid sample. The bench holds in_valid high through the change cycle and the flush cycle, then presents one more sample. It expects that single later sample, and only that sample, at the output.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_RRC    = 2'b01,
        MODE_IDD    = 2'b10,
        MODE_CASC   = 2'b11
    } mfc_mode_e;

    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } mfc_state_e;

    localparam int RRC_TAPS = 15;
    localparam int COEF_W   = 9;

    // Symmetric pulse-shaping taps, folded about the centre tap.
    function automatic logic signed [COEF_W-1:0] rrc_coef(input int idx);
        int f;
        f = (idx > RRC_TAPS / 2) ? (RRC_TAPS - 1 - idx) : idx;
        case (f)
            0:       return -9'sd3;
            1:       return 9'sd8;
            2:       return 9'sd12;
            3:       return -9'sd15;
            4:       return -9'sd37;
            5:       return 9'sd21;
            6:       return 9'sd166;
            7:       return 9'sd255;
            default: return 9'sd0;
        endcase
    endfunction

    function automatic int floor_log2(input int v);
        int r;
        r = 0;
        for (int b = 1; b < 31; b++) begin
            if ((v >> b) != 0) r = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
    import mfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mfc_mode_e mode_i,
    input  logic      in_valid,
    output mfc_mode_e mode_q,
    output logic      clear_o,
    output logic      accept_o
);

    mfc_state_e state_q;
    mfc_state_e state_d;
    logic       mode_chg;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
            mode_q  <= MODE_BYPASS;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = ST_RUN;
            ST_RUN:   if (mode_i != mode_q) state_d = ST_FLUSH;
            default:  state_d = ST_FLUSH;
        endcase
    end

    // Outputs
    always_comb begin
        mode_chg = (mode_i != mode_q);
        clear_o  = (state_q == ST_FLUSH) || mode_chg;
        accept_o = in_valid && !clear_o;
    end

    // R10
    flush_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_RUN));

    // R8
    drop_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |-> !accept_o);

endmodule

// File: rtl/mfc_idd.sv
module mfc_idd
    import mfc_pkg::*;
#(
    parameter int IW        = 12,
    parameter int MAX_RATIO = 16,
    localparam int RW       = $clog2(MAX_RATIO) + 1,
    localparam int SHW      = $clog2($clog2(MAX_RATIO) + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 sym_clr,
    input  logic                 use_idd,
    input  logic [RW-1:0]        ratio,
    input  logic                 in_valid,
    input  logic signed [IW-1:0] in_i,
    input  logic signed [IW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [IW-1:0] out_i,
    output logic signed [IW-1:0] out_q
);

    localparam int SW = IW + $clog2(MAX_RATIO) + 1;
    localparam logic signed [SW-1:0] SAT_HI = SW'((1 << (IW - 1)) - 1);
    localparam logic signed [SW-1:0] SAT_LO = -SAT_HI - SW'(1);

    logic [RW-1:0]  ratio_eff;
    logic [SHW-1:0] sh;
    logic [RW-1:0]  cnt_q;
    logic [RW-1:0]  base_cnt;
    logic [RW:0]    nxt_cnt;
    logic           last;

    logic signed [IW-1:0] x [2];
    logic signed [IW-1:0] y [2];

    assign x[0]  = in_i;
    assign x[1]  = in_q;
    assign out_i = y[0];
    assign out_q = y[1];

    always_comb begin
        if (ratio == '0)                    ratio_eff = RW'(1);
        else if (ratio > RW'(MAX_RATIO))    ratio_eff = RW'(MAX_RATIO);
        else                                ratio_eff = ratio;
        sh       = SHW'(floor_log2(int'(ratio_eff)));
        base_cnt = sym_clr ? '0 : cnt_q;
        nxt_cnt  = {1'b0, base_cnt} + (RW+1)'(1);
        last     = (nxt_cnt >= {1'b0, ratio_eff});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid && (!use_idd || last);
            if (in_valid && use_idd) cnt_q <= last ? '0 : nxt_cnt[RW-1:0];
            else if (sym_clr)        cnt_q <= '0;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [SW-1:0] acc_q;
        logic signed [SW-1:0] base;
        logic signed [SW-1:0] sum;
        logic signed [SW-1:0] scaled;
        logic signed [IW-1:0] sat_v;
        logic signed [IW-1:0] y_q;

        always_comb begin
            base   = sym_clr ? '0 : acc_q;
            sum    = base + {{(SW-IW){x[g][IW-1]}}, x[g]};
            scaled = sum >>> sh;
            if (scaled > SAT_HI)      sat_v = SAT_HI[IW-1:0];
            else if (scaled < SAT_LO) sat_v = SAT_LO[IW-1:0];
            else                      sat_v = scaled[IW-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                acc_q <= '0;
                y_q   <= '0;
            end else if (in_valid && use_idd) begin
                acc_q <= last ? '0 : sum;
                if (last) y_q <= sat_v;
            end else if (in_valid) begin
                y_q <= x[g];
            end else if (sym_clr) begin
                acc_q <= '0;
            end
        end

        assign y[g] = y_q;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RW'(MAX_RATIO - 1));

    // R7
    restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_clr && !in_valid && !clear) |=> (cnt_q == '0));

endmodule

// File: rtl/mfc_rrc.sv
module mfc_rrc
    import mfc_pkg::*;
#(
    parameter int IW   = 12,
    parameter int CSH  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 use_rrc,
    input  logic                 in_valid,
    input  logic signed [IW-1:0] in_i,
    input  logic signed [IW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [IW-1:0] out_i,
    output logic signed [IW-1:0] out_q
);

    localparam int AW   = IW + COEF_W + $clog2(RRC_TAPS);
    localparam int HALF = 1 << (CSH - 1);
    localparam logic signed [AW-1:0] SAT_HI = AW'((1 << (IW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);

    logic signed [IW-1:0] x [2];
    logic signed [IW-1:0] y [2];

    assign x[0]  = in_i;
    assign x[1]  = in_q;
    assign out_i = y[0];
    assign out_q = y[1];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) out_valid <= 1'b0;
        else                 out_valid <= in_valid;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [IW-1:0] dl_q [RRC_TAPS-1];
        logic signed [IW-1:0] win  [RRC_TAPS];
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] rnd;
        logic signed [IW-1:0] sat_v;
        logic signed [IW-1:0] y_q;

        always_comb begin
            win[0] = x[g];
            for (int k = 1; k < RRC_TAPS; k++) win[k] = dl_q[k-1];
        end

        always_comb begin
            acc = '0;
            for (int k = 0; k < RRC_TAPS; k++) begin
                acc = acc + AW'(win[k]) * AW'(rrc_coef(k));
            end
            rnd = (acc + AW'(HALF)) >>> CSH;
            if (rnd > SAT_HI)      sat_v = SAT_HI[IW-1:0];
            else if (rnd < SAT_LO) sat_v = SAT_LO[IW-1:0];
            else                   sat_v = rnd[IW-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                for (int k = 0; k < RRC_TAPS - 1; k++) dl_q[k] <= '0;
                y_q <= '0;
            end else if (in_valid) begin
                if (use_rrc) begin
                    dl_q[0] <= x[g];
                    for (int k = 1; k < RRC_TAPS - 1; k++) dl_q[k] <= dl_q[k-1];
                    y_q <= sat_v;
                end else begin
                    y_q <= x[g];
                end
            end
        end

        assign y[g] = y_q;
    end

    // R2
    one_out_per_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

// File: rtl/mfc_chain.sv
module mfc_chain
    import mfc_pkg::*;
#(
    parameter int IN_W       = 12,
    parameter int MAX_RATIO  = 16,
    parameter int COEF_SHIFT = 8,
    localparam int RW        = $clog2(MAX_RATIO) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic [RW-1:0]          dump_ratio,
    input  logic                   sym_clr,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   out_valid,
    output logic signed [IN_W-1:0] out_i,
    output logic signed [IN_W-1:0] out_q
);

    mfc_mode_e            mode_q;
    logic                 clear;
    logic                 accept;
    logic                 idd_valid;
    logic signed [IN_W-1:0] idd_i;
    logic signed [IN_W-1:0] idd_q;

    mfc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mfc_mode_e'(mode)),
        .in_valid (in_valid),
        .mode_q   (mode_q),
        .clear_o  (clear),
        .accept_o (accept)
    );

    mfc_idd #(.IW(IN_W), .MAX_RATIO(MAX_RATIO)) u_idd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .sym_clr   (sym_clr),
        .use_idd   (mode_q[1]),
        .ratio     (dump_ratio),
        .in_valid  (accept),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (idd_valid),
        .out_i     (idd_i),
        .out_q     (idd_q)
    );

    mfc_rrc #(.IW(IN_W), .CSH(COEF_SHIFT)) u_rrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .use_rrc   (mode_q[0]),
        .in_valid  (idd_valid),
        .in_i      (idd_i),
        .in_q      (idd_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    // R1
    bypass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == MODE_BYPASS) |-> $past(accept, 2));

    // R8
    cleared_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> ##1 !out_valid ##1 !out_valid);

endmodule

// File: tb/sim_mfc_chain.sv
module sim_mfc_chain;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic [4:0]        dump_ratio = 5'd1;
    logic              sym_clr = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic              out_valid;
    logic signed [11:0] out_i;
    logic signed [11:0] out_q;

    int n_run  = 0;
    int n_fail = 0;
    bit cap_en = 1'b0;
    int cap_n  = 0;
    int cap_i [256];
    int cap_q [256];
    int exp_i [256];
    int exp_q [256];
    int exp_n;
    int xi [128];
    int xq [128];

    always #4 clk = ~clk;

    mfc_chain u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dump_ratio(dump_ratio),
        .sym_clr(sym_clr), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always @(negedge clk) begin
        if (cap_en && out_valid && cap_n < 256) begin
            cap_i[cap_n] = int'(out_i);
            cap_q[cap_n] = int'(out_q);
            cap_n++;
        end
    end

    // {mode[1:0], ratio[4:0], pattern[1:0], count[7:0]}
    localparam logic [16:0] VEC [10] = '{
        {2'd0, 5'd1,  2'd0, 8'd10},
        {2'd1, 5'd1,  2'd0, 8'd24},
        {2'd1, 5'd1,  2'd2, 8'd20},
        {2'd2, 5'd4,  2'd0, 8'd32},
        {2'd2, 5'd3,  2'd2, 8'd12},
        {2'd2, 5'd16, 2'd3, 8'd64},
        {2'd3, 5'd8,  2'd3, 8'd96},
        {2'd3, 5'd2,  2'd1, 8'd40},
        {2'd2, 5'd0,  2'd0, 8'd8},
        {2'd2, 5'd20, 2'd1, 8'd48}
    };

    function automatic string vec_req(input int idx);
        case (idx)
            0:       return "R1";
            1:       return "R2";
            2, 4:    return "R6";
            3, 5:    return "R3";
            6, 7:    return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat12(input int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int tap(input int k);
        int t [8] = '{-3, 8, 12, -15, -37, 21, 166, 255};
        return (k > 7) ? t[14 - k] : t[k];
    endfunction

    function automatic int flog2(input int v);
        int r = 0;
        for (int b = 1; b < 8; b++) if ((v >> b) != 0) r = b;
        return r;
    endfunction

    function automatic int pat(input int p, input int k, input int lane);
        case (p)
            0:       return ((k * 123 + lane * 700) % 4000) - 2000;
            1:       return ((k % 2) == lane) ? 1500 : -1500;
            2:       return (lane == 0) ? 2047 : -2048;
            default: return (lane == 0) ? ((((k / 8) % 2) == 1) ? 1000 : -1000)
                                        : ((((k / 4) % 2) == 1) ? -600 : 600);
        endcase
    endfunction

    // Expected stream from requirements R1..R6
    task automatic model(input int md, input int ratio, input int n);
        int ai [128];
        int aq [128];
        int an, re, sh, si, sq, cnt;
        int hi [15];
        int hq [15];
        an = 0;
        if (md >= 2) begin
            re = (ratio == 0) ? 1 : ((ratio > 16) ? 16 : ratio);
            sh = flog2(re);
            si = 0; sq = 0; cnt = 0;
            for (int k = 0; k < n; k++) begin
                si += xi[k]; sq += xq[k]; cnt++;
                if (cnt >= re) begin
                    ai[an] = sat12(si >>> sh);
                    aq[an] = sat12(sq >>> sh);
                    an++; si = 0; sq = 0; cnt = 0;
                end
            end
        end else begin
            for (int k = 0; k < n; k++) begin
                ai[k] = xi[k]; aq[k] = xq[k];
            end
            an = n;
        end
        exp_n = an;
        if ((md % 2) == 1) begin
            for (int j = 0; j < 15; j++) begin hi[j] = 0; hq[j] = 0; end
            for (int k = 0; k < an; k++) begin
                for (int j = 14; j > 0; j--) begin hi[j] = hi[j-1]; hq[j] = hq[j-1]; end
                hi[0] = ai[k]; hq[0] = aq[k];
                si = 0; sq = 0;
                for (int j = 0; j < 15; j++) begin
                    si += tap(j) * hi[j];
                    sq += tap(j) * hq[j];
                end
                exp_i[k] = sat12((si + 128) >>> 8);
                exp_q[k] = sat12((sq + 128) >>> 8);
            end
        end else begin
            for (int k = 0; k < an; k++) begin exp_i[k] = ai[k]; exp_q[k] = aq[k]; end
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        in_valid = 1'b0;
        mode = m ^ 2'b01;
        repeat (2) @(negedge clk);
        mode = m;
        repeat (3) @(negedge clk);
    endtask

    task automatic feed(input int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_i = 12'(xi[k]);
            in_q = 12'(xq[k]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input string req);
        chk(cap_n == exp_n, req, cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            chk(cap_i[k] == exp_i[k], req, cap_i[k], exp_i[k]);
            chk(cap_q[k] == exp_q[k], "R11", cap_q[k], exp_q[k]);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int md, rt, pt, n;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);

        // Table of vectors
        for (int v = 0; v < 10; v++) begin
            md = int'(VEC[v][16:15]);
            rt = int'(VEC[v][14:10]);
            pt = int'(VEC[v][9:8]);
            n  = int'(VEC[v][7:0]);
            for (int k = 0; k < n; k++) begin
                xi[k] = pat(pt, k, 0);
                xq[k] = pat(pt, k, 1);
            end
            dump_ratio = 5'(rt);
            set_mode(2'(md));
            cap_n = 0; cap_en = 1'b1;
            feed(n);
            cap_en = 1'b0;
            model(md, rt, n);
            compare(vec_req(v));
        end

        // R1: two-cycle latency in bypass
        set_mode(2'b00);
        in_valid = 1'b1; in_i = 12'sd77; in_q = -12'sd5;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
        chk(out_i == 12'sd77, "R1", int'(out_i), 77);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // R8, R10: samples in change and flush cycles dropped, third accepted
        dump_ratio = 5'd1;
        set_mode(2'b01);
        cap_n = 0; cap_en = 1'b1;
        mode = 2'b10; in_valid = 1'b1; in_i = 12'sd1000; in_q = 12'sd1000;
        @(negedge clk);
        @(negedge clk);
        in_i = 12'sd555; in_q = -12'sd555;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        cap_en = 1'b0;
        chk(cap_n == 1, "R8", cap_n, 1);
        chk(cap_i[0] == 555, "R10", cap_i[0], 555);
        chk(cap_q[0] == -555, "R11", cap_q[0], -555);

        // R8: FIR history cleared by a mode change
        for (int k = 0; k < 15; k++) begin xi[k] = 2047; xq[k] = -2048; end
        set_mode(2'b01);
        feed(15);
        set_mode(2'b01);
        for (int k = 0; k < 15; k++) begin
            xi[k] = (k == 0) ? 256 : 0;
            xq[k] = (k == 0) ? -256 : 0;
        end
        cap_n = 0; cap_en = 1'b1;
        feed(15);
        cap_en = 1'b0;
        chk(cap_n == 15, "R8", cap_n, 15);
        for (int k = 0; k < 15; k++) begin
            chk(cap_i[k] == tap(k), "R8", cap_i[k], tap(k));
            chk(cap_q[k] == -tap(k), "R11", cap_q[k], -tap(k));
        end

        // R7: restart strobe coincides with a valid sample
        dump_ratio = 5'd4;
        set_mode(2'b10);
        cap_n = 0; cap_en = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            in_valid = 1'b1;
            sym_clr = (k == 3);
            in_i = 12'(k * 10);
            in_q = 12'(-k * 10);
            @(negedge clk);
        end
        in_valid = 1'b0; sym_clr = 1'b0;
        repeat (4) @(negedge clk);
        cap_en = 1'b0;
        chk(cap_n == 1, "R7", cap_n, 1);
        chk(cap_i[0] == 45, "R7", cap_i[0], 45);
        chk(cap_q[0] == -45, "R7", cap_q[0], -45);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule